// File: doc/BRIEF.md
# Lane Activity Monitor with Change Interrupt

This block watches a set of already-digitized input lanes and reports, once per sampling window, which lanes stayed quiet. Each lane has its own transition counter. A lane counts as alive in a window only when it has toggled at least twice. A slow monitor strobe, running at up to a few MHz and asynchronous to the system clock, closes each window. Every strobe rising edge moves the alive/quiet verdicts of all lanes into status registers and starts a new window.

Software reads the status through a simple address-plus-read-strobe port. Lanes are packed four per status word, and the last word holds the single leftover lane. An active-low interrupt flags that the picture has changed. It is raised when a sample differs from the previous sample in any word, not merely because a lane is quiet. A read of a word acknowledges only that word's change, and the stored status is left as it is. The interrupt therefore drops only after every changed word has been read.

The lanes and the strobe pass through two-flop synchronizers into the system clock domain. Transitions and the strobe edge are detected on these synchronized copies.

Top module: `lam_monitor`

## Requirements
- R1: After reset `irq_n_o` is 1 and `rd_data_o` is 0. Every status bit that maps to a lane reads 1 (no activity), and unused bits read 0.
- R2: A lane with two or more transitions in a window reports 0 (active) after the closing sample. A lane with zero transitions or exactly one transition reports 1 (quiet).
- R3: The word at address 0x21+k holds lanes 4k to 4k+3, and lane n sits at bit n mod 4, for k = 0 to 3. Address 0x25 holds lane 16 in bit 0 with bits 3:1 reading 0. Read data appears on `rd_data_o` at the clock edge that accepts `rd_en_i`.
- R4: Each sample restarts every lane's window. A lane active in one window and idle in the next reports 1 after the second sample.
- R5: A sample that changes any bit of any word drives `irq_n_o` low. A sample that changes nothing leaves `irq_n_o` unchanged.
- R6: Reading a word clears only that word's pending change and never alters the stored status. Two reads of the same word return the same value.
- R7: When several words changed, `irq_n_o` stays low until each of them has been read.
- R8: A read of an address outside 0x21 to 0x25 returns 0 and clears no pending change.
- R9: A sample takes effect at the third system clock edge after `mon_clk_i` rises. If a read of a word is accepted at that same edge, and the sample changes that word, the word's pending change stays set. The read returns the value held before the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lanes_i | input | 17 | Digitized lane inputs, asynchronous |
| mon_clk_i | input | 1 | Slow monitor strobe; each rising edge closes a window |
| rd_en_i | input | 1 | Read strobe, one access per cycle held high |
| rd_addr_i | input | 6 | Status word address |
| rd_data_o | output | 4 | Registered read data |
| irq_n_o | output | 1 | Active-low change interrupt |

## Verification
The bench counts exactly one transition on a lane and expects it to read quiet. A detector that fires on the first edge would report it as active. It runs a window that changes two words and reads them one at a time. A single shared acknowledge would drop the interrupt too early, and a read that disturbed the state would return a different second value. It also lets a window repeat the previous activity pattern, where a level-driven interrupt would fire wrongly, and reads addresses just outside the map. Finally it places a read exactly on the sampling edge: if the clear won over the set, that word's change would be lost and the interrupt would rise while the change is still unread.

// File: rtl/lam_pkg.sv
package lam_pkg;
   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction
endpackage

// File: rtl/lam_sync.sv
module lam_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lam_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("lam_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= din;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/lam_lane_det.sv
module lam_lane_det #(
   parameter int MIN_EDGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lane_i,
   input  logic sample_i,
   output logic idle_o
);
   localparam int CNT_W = $clog2(MIN_EDGES + 1);

   if (MIN_EDGES < 1) begin : g_bad_edges
      $error("lam_lane_det: MIN_EDGES must be at least 1");
   end

   logic             lane_q;
   logic [CNT_W-1:0] cnt_q;
   logic             edge_seen;

   assign edge_seen = lane_i ^ lane_q;

   // an edge seen in the sampling cycle belongs to the new window
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lane_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         lane_q <= lane_i;
         if (sample_i) begin
            cnt_q <= edge_seen ? CNT_W'(1) : '0;
         end else if (edge_seen && (cnt_q != CNT_W'(MIN_EDGES))) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign idle_o = (cnt_q < CNT_W'(MIN_EDGES));

   // R2: counter saturates at the activity threshold
   a_r2_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(MIN_EDGES));

   // R4: a sample restarts the window
   a_r4_window_restart: assert property (@(posedge clk) disable iff (!rst_n)
      sample_i |=> (cnt_q <= CNT_W'(1)));
endmodule

// File: rtl/lam_regfile.sv
module lam_regfile
   import lam_pkg::*;
#(
   parameter int          NUM_LANES = 17,
   parameter int          PER_REG   = 4,
   parameter int          ADDR_W    = 6,
   parameter int unsigned BASE_ADDR = 'h21
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sample_i,
   input  logic [NUM_LANES-1:0] idle_i,
   input  logic                 rd_en_i,
   input  logic [ADDR_W-1:0]    rd_addr_i,
   output logic [PER_REG-1:0]   rd_data_o,
   output logic                 irq_n_o
);
   localparam int NREG = ceil_div(NUM_LANES, PER_REG);
   localparam int PAD  = NREG * PER_REG;
   localparam logic [PAD-1:0] RST_PAT = PAD'({NUM_LANES{1'b1}});

   if (BASE_ADDR + NREG > (1 << ADDR_W)) begin : g_bad_map
      $error("lam_regfile: status words do not fit the address space");
   end
   if (PER_REG < 1) begin : g_bad_per
      $error("lam_regfile: PER_REG must be at least 1");
   end

   logic [PAD-1:0]     mon_q;
   logic [PAD-1:0]     idle_pad;
   logic [NREG-1:0]    pend_q;
   logic [NREG-1:0]    chg;
   logic [NREG-1:0]    rd_hit;
   logic [PER_REG-1:0] rd_sel;

   assign idle_pad = PAD'(idle_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mon_q <= RST_PAT;
      end else if (sample_i) begin
         mon_q <= idle_pad;
      end
   end

   for (genvar k = 0; k < NREG; k++) begin : g_word
      assign chg[k]    = (mon_q[k*PER_REG +: PER_REG] != idle_pad[k*PER_REG +: PER_REG]);
      assign rd_hit[k] = rd_en_i && (rd_addr_i == ADDR_W'(BASE_ADDR + k));

      // a change at sampling outranks an acknowledge in the same cycle
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_q[k] <= 1'b0;
         end else if (sample_i && chg[k]) begin
            pend_q[k] <= 1'b1;
         end else if (rd_hit[k]) begin
            pend_q[k] <= 1'b0;
         end
      end

      // R9: set beats clear
      a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (sample_i && chg[k]) |=> pend_q[k]);
   end

   always_comb begin
      rd_sel = '0;
      for (int k = 0; k < NREG; k++) begin
         if (rd_hit[k]) begin
            rd_sel = mon_q[k*PER_REG +: PER_REG];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data_o <= '0;
      end else if (rd_en_i) begin
         rd_data_o <= rd_sel;
      end
   end

   assign irq_n_o = ~|pend_q;

   // R5: the interrupt only falls after a sample
   a_r5_irq_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n_o) |-> $past(sample_i));

   // R6: reads never touch stored status
   a_r6_state_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_i |=> $stable(mon_q));

   // R7: with no read and no sample the interrupt holds
   a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n_o && !sample_i && !rd_en_i) |=> !irq_n_o);

   // R8: unmapped reads return zero
   a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && !(|rd_hit)) |=> (rd_data_o == '0));
endmodule

// File: rtl/lam_monitor.sv
module lam_monitor #(
   parameter int          NUM_LANES   = 17,
   parameter int          PER_REG     = 4,
   parameter int          ADDR_W      = 6,
   parameter int unsigned BASE_ADDR   = 'h21,
   parameter int          MIN_EDGES   = 2,
   parameter int          SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LANES-1:0] lanes_i,
   input  logic                 mon_clk_i,
   input  logic                 rd_en_i,
   input  logic [ADDR_W-1:0]    rd_addr_i,
   output logic [PER_REG-1:0]   rd_data_o,
   output logic                 irq_n_o
);
   if (NUM_LANES < 1) begin : g_bad_lanes
      $error("lam_monitor: NUM_LANES must be at least 1");
   end

   logic [NUM_LANES-1:0] lanes_s;
   logic [NUM_LANES-1:0] idle;
   logic                 mclk_s;
   logic                 mclk_q;
   logic                 sample;

   lam_sync #(.WIDTH(NUM_LANES), .STAGES(SYNC_STAGES)) u_lane_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (lanes_i),
      .dout (lanes_s)
   );

   lam_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_mclk_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (mon_clk_i),
      .dout (mclk_s)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mclk_q <= 1'b0;
      end else begin
         mclk_q <= mclk_s;
      end
   end

   assign sample = mclk_s & ~mclk_q;

   for (genvar n = 0; n < NUM_LANES; n++) begin : g_lane
      lam_lane_det #(.MIN_EDGES(MIN_EDGES)) u_det (
         .clk     (clk),
         .rst_n   (rst_n),
         .lane_i  (lanes_s[n]),
         .sample_i(sample),
         .idle_o  (idle[n])
      );
   end

   lam_regfile #(
      .NUM_LANES(NUM_LANES),
      .PER_REG  (PER_REG),
      .ADDR_W   (ADDR_W),
      .BASE_ADDR(BASE_ADDR)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sample_i (sample),
      .idle_i   (idle),
      .rd_en_i  (rd_en_i),
      .rd_addr_i(rd_addr_i),
      .rd_data_o(rd_data_o),
      .irq_n_o  (irq_n_o)
   );

   // R4: samples are single-cycle pulses
   a_r4_sample_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      sample |=> !sample);
endmodule

// File: tb/lam_monitor_tb.sv
module lam_monitor_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [16:0] lanes = '0;
   logic        mon_clk = 1'b0;
   logic        rd_en = 1'b0;
   logic [5:0]  rd_addr = '0;
   logic [3:0]  rd_data;
   logic        irq_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model
   int         tcnt [17];
   logic [3:0] mreg [5];
   bit         mpend [5];

   // scoreboard
   logic [3:0] exp_dat [$];
   string      exp_tag [$];
   logic       rd_fire = 1'b0;

   always #4 clk = ~clk;

   lam_monitor u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .lanes_i  (lanes),
      .mon_clk_i(mon_clk),
      .rd_en_i  (rd_en),
      .rd_addr_i(rd_addr),
      .rd_data_o(rd_data),
      .irq_n_o  (irq_n)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) rd_fire <= rd_en;

   always @(negedge clk) begin
      if (rd_fire) begin
         if (exp_dat.size() == 0) begin
            chk(1'b0, "scoreboard empty", int'(rd_data), 0);
         end else begin
            logic [3:0] e;
            string t;
            e = exp_dat.pop_front();
            t = exp_tag.pop_front();
            chk(rd_data === e, t, int'(rd_data), int'(e));
         end
      end
   end

   function automatic bit exp_irq_n();
      bit any = 1'b0;
      for (int k = 0; k < 5; k++) any |= mpend[k];
      return !any;
   endfunction

   function automatic void model_sample();
      logic [3:0] nw [5];
      for (int k = 0; k < 5; k++) nw[k] = 4'h0;
      for (int l = 0; l < 17; l++) begin
         nw[l/4][l%4] = (tcnt[l] < 2);
         tcnt[l] = 0;
      end
      for (int k = 0; k < 5; k++) begin
         if (nw[k] != mreg[k]) mpend[k] = 1'b1;
         mreg[k] = nw[k];
      end
   endfunction

   task automatic toggle(input logic [16:0] mask, input int times);
      for (int i = 0; i < times; i++) begin
         @(negedge clk);
         lanes = lanes ^ mask;
         for (int l = 0; l < 17; l++) if (mask[l]) tcnt[l]++;
         repeat (4) @(negedge clk);
      end
   endtask

   task automatic mon_pulse();
      repeat (4) @(negedge clk);
      mon_clk = 1'b1;
      repeat (6) @(negedge clk);
      mon_clk = 1'b0;
      repeat (6) @(negedge clk);
      model_sample();
   endtask

   task automatic do_read(input int addr, input string tag);
      @(negedge clk);
      rd_en = 1'b1;
      rd_addr = 6'(addr);
      if (addr >= 'h21 && addr <= 'h25) begin
         exp_dat.push_back(mreg[addr - 'h21]);
         mpend[addr - 'h21] = 1'b0;
      end else begin
         exp_dat.push_back(4'h0);
      end
      exp_tag.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic chk_irq(input string tag);
      bit e;
      e = exp_irq_n();
      chk(irq_n === e, tag, int'(irq_n), int'(e));
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int l = 0; l < 17; l++) tcnt[l] = 0;
      for (int k = 0; k < 4; k++) mreg[k] = 4'hF;
      mreg[4] = 4'h1;
      for (int k = 0; k < 5; k++) mpend[k] = 1'b0;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(irq_n === 1'b1, "R1 irq after reset", int'(irq_n), 1);
      chk(rd_data === 4'h0, "R1 rd_data after reset", int'(rd_data), 0);
      for (int a = 'h21; a <= 'h25; a++) do_read(a, "R1 R3 reset status word");

      // R5 quiet window, no change
      mon_pulse();
      chk_irq("R5 no change keeps irq high");

      // R2 R3 R5: lane5 twice, lane9 once, lane16 twice
      toggle(17'h00020, 2);
      toggle(17'h00200, 1);
      toggle(17'h10000, 2);
      mon_pulse();
      chk_irq("R5 change drives irq low");
      do_read('h22, "R3 lane5 word");
      chk_irq("R7 irq held while lane16 word unread");
      do_read('h22, "R6 second read same value");
      do_read('h25, "R3 lane16 word");
      chk_irq("R7 irq released after all read");
      do_read('h23, "R2 single transition reads quiet");

      // R4 quiet window after activity
      mon_pulse();
      chk_irq("R4 return to quiet is a change");
      do_read('h20, "R8 below map");
      do_read('h26, "R8 above map");
      chk_irq("R8 unmapped read clears nothing");
      do_read('h22, "R4 lane5 quiet again");
      do_read('h25, "R4 lane16 quiet again");
      chk_irq("R7 irq released");

      // R2 R3 bit positions
      toggle(17'h09009, 3);
      mon_pulse();
      for (int a = 'h21; a <= 'h25; a++) do_read(a, "R3 bit position pattern");
      chk_irq("R6 reads acknowledge");

      // R5 identical activity, no change
      toggle(17'h09009, 2);
      mon_pulse();
      chk_irq("R5 repeated pattern no irq");

      // R9 read on the sampling edge; quiet window changes words 0x21 and 0x24
      repeat (4) @(negedge clk);
      mon_clk = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b1;
      rd_addr = 6'h21;
      exp_dat.push_back(mreg[0]);
      exp_tag.push_back("R9 read on sample edge returns old value");
      @(negedge clk);
      rd_en = 1'b0;
      model_sample();
      repeat (4) @(negedge clk);
      mon_clk = 1'b0;
      repeat (4) @(negedge clk);
      do_read('h24, "R9 other changed word");
      chk_irq("R9 set kept over same-cycle read");
      do_read('h21, "R9 new value after sample");
      chk_irq("R9 irq released after final read");

      repeat (4) @(negedge clk);
      chk(exp_dat.size() == 0, "scoreboard drained", exp_dat.size(), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule